// File: doc/BRIEF.md
# Parallel Bus Initiator Controller

This block is the master-side sequencer for a 32-bit parallel bus on which address and data share the same wires. A local agent hands it one transaction at a time: a 4-bit command code, a start address and a count of data phases. For each data phase the agent supplies the byte enables and, for writes, the data word. The agent selects these by the phase index that the block exposes. On reads, the block returns each received word with a one-clock valid strobe.

The block raises its bus request and waits for a grant while the bus is idle, meaning both frame and initiator-ready are seen high. It then drives a single address phase followed by data phases. A word moves on every clock edge where initiator-ready and target-ready are both low. When the transaction is over, the block releases the bus through a turnaround clock and pulses done with a 2-bit status. The status tells the agent whether the transfer completed normally, was stopped by the target, was master-aborted because no target claimed it, or was target-aborted. Every bus output comes as a value and an output-enable pair, so the pads or the bus model do the resolving.

Top module: `bus_initiator`

## Requirements
- R1: While reset is low, and until a request is accepted, every output enable is off, bus_req_n is high, done is low and req_ready is high. Reset is asynchronous and active low.
- R2: A request accepted while idle drives bus_req_n low on the next clock. The address phase starts only after a clock edge that samples bus_gnt_n low together with frame_n_i and irdy_n_i both high. bus_req_n stays low through the address phase.
- R3: The address phase lasts one clock. In it frame is driven low, initiator-ready is driven high, the AD bus carries the address, and C/BE carries the command code unchanged.
- R4: In every data phase initiator-ready is driven low. Frame is driven high only in the final phase. The phase index advances only on an edge that samples trdy_n_i low. A requested length of 0 runs as a single phase.
- R5: A command with bit 0 set is a write: the AD bus carries wr_data for the current phase index. Any other command is a read: AD is left undriven, and the word sampled on each transfer edge appears on rd_data with rd_valid high for exactly the next clock.
- R6: During data phases C/BE carries the inverse of ph_be (a 1 in ph_be enables that byte). This may change from phase to phase. A phase with no bytes enabled completes like any other.
- R7: par_o is driven one clock after each clock in which the block drove AD. It gives even parity, so the XOR of the 32 AD bits, the 4 C/BE bits and par_o is 0. par_oe follows AD's enable with one clock of delay.
- R8: A target that never drives devsel_n_i low during the first 6 data-phase clocks causes a master abort on the 6th such edge, with status 2. Devsel first seen on the 6th clock avoids the abort.
- R9: stop_n_i low while devsel_n_i is low ends the transaction with status 1 (retry or disconnect). If trdy_n_i is also low on that edge, that word still transfers.
- R10: stop_n_i low while devsel_n_i is high ends the transaction with status 3 (target abort), and no word transfers.
- R11: If a transaction ends while frame is still driven low, one clock follows with frame driven high and initiator-ready still low.
- R12: Last comes one turnaround clock with frame and initiator-ready driven high and AD and C/BE released. Then comes one clock with every enable off, done high and the status valid. The block is then idle again.
- R13: Normal completion (frame already high on the final phase when target-ready is sampled low) reports status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local transaction request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_cmd | input | 4 | Command code for the address phase |
| req_addr | input | 32 | Start address |
| req_len | input | LEN_W | Number of data phases (0 runs as 1) |
| ph_idx | output | LEN_W | Index of the current data phase |
| wr_data | input | 32 | Write word for phase ph_idx |
| ph_be | input | 4 | Active-high byte enables for phase ph_idx |
| rd_data | output | 32 | Last read word |
| rd_valid | output | 1 | rd_data holds a new word |
| done | output | 1 | Transaction finished, status valid |
| status | output | 2 | 0 normal, 1 stop/retry, 2 master abort, 3 target abort |
| bus_req_n | output | 1 | Bus request, active low |
| bus_gnt_n | input | 1 | Bus grant, active low |
| frame_n_o | output | 1 | Frame value |
| frame_oe | output | 1 | Frame output enable |
| frame_n_i | input | 1 | Frame as seen on the bus |
| irdy_n_o | output | 1 | Initiator-ready value |
| irdy_oe | output | 1 | Initiator-ready output enable |
| irdy_n_i | input | 1 | Initiator-ready as seen on the bus |
| trdy_n_i | input | 1 | Target ready, active low |
| devsel_n_i | input | 1 | Device select, active low |
| stop_n_i | input | 1 | Target stop, active low |
| ad_o | output | 32 | AD value |
| ad_oe | output | 1 | AD output enable |
| ad_i | input | 32 | AD as seen on the bus |
| cbe_n_o | output | 4 | Command / byte-enable value |
| cbe_oe | output | 1 | C/BE output enable |
| par_o | output | 1 | Parity value |
| par_oe | output | 1 | Parity output enable |

## Verification
The hardest cases to reach from the ports are the endings that do not arrive on a completing transfer. These are the master-abort count that lands on exactly the sixth data clock, and a stop that arrives while frame is still low, which forces the extra frame-release clock. The bench acts as the arbiter and the target. For each transaction it is scripted with a grant delay, a period in which another master holds the bus, a devsel delay, wait states per phase, and a stop phase of a chosen kind. A behavioural model stepped once per clock predicts every bus output, the parity of the previous clock and the status. Devsel delays of 5 and of never sit on either side of the abort boundary, and stops in the middle of a burst reach the release clock.

// File: rtl/bus_initiator.sv
module bus_initiator #(
  parameter int LEN_W      = 8,
  parameter int DSEL_LIMIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_cmd,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic [LEN_W-1:0] ph_idx,
  input  logic [31:0]      wr_data,
  input  logic [3:0]       ph_be,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic [1:0]       status,
  output logic             bus_req_n,
  input  logic             bus_gnt_n,
  output logic             frame_n_o,
  output logic             frame_oe,
  input  logic             frame_n_i,
  output logic             irdy_n_o,
  output logic             irdy_oe,
  input  logic             irdy_n_i,
  input  logic             trdy_n_i,
  input  logic             devsel_n_i,
  input  logic             stop_n_i,
  output logic [31:0]      ad_o,
  output logic             ad_oe,
  input  logic [31:0]      ad_i,
  output logic [3:0]       cbe_n_o,
  output logic             cbe_oe,
  output logic             par_o,
  output logic             par_oe
);

  localparam int TW = $clog2(DSEL_LIMIT + 1);
  localparam logic [1:0] END_OK = 2'd0, END_STOP = 2'd1, END_MABT = 2'd2, END_TABT = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_ADDR, S_DATA, S_FIN, S_TURN, S_DONE} st_t;

  st_t              st;
  logic [3:0]       cmd_q;
  logic [31:0]      addr_q;
  logic [LEN_W-1:0] left_q, idx_q;
  logic [TW-1:0]    tmr_q;
  logic             seen_q;
  logic [1:0]       status_q;
  logic [31:0]      rd_data_q;
  logic             rd_valid_q, par_q, par_oe_q;

  wire in_data = (st == S_DATA);
  wire is_wr   = cmd_q[0];
  wire last    = (left_q <= LEN_W'(1));
  wire t_abort = in_data && !stop_n_i && devsel_n_i;
  wire t_stop  = in_data && !stop_n_i && !devsel_n_i;
  wire xfer    = in_data && !trdy_n_i && !t_abort;
  wire fin_ok  = xfer && last && stop_n_i;
  wire m_abort = in_data && !seen_q && devsel_n_i && stop_n_i && (tmr_q == TW'(DSEL_LIMIT - 1));
  wire finish  = t_abort || t_stop || fin_ok || m_abort;

  assign req_ready = (st == S_IDLE);
  assign bus_req_n = !(st == S_REQ || st == S_ADDR);
  assign frame_oe  = (st == S_ADDR) || in_data || (st == S_FIN) || (st == S_TURN);
  assign irdy_oe   = frame_oe;
  assign frame_n_o = !((st == S_ADDR) || (in_data && !last));
  assign irdy_n_o  = !(in_data || (st == S_FIN));
  assign ad_oe     = (st == S_ADDR) || ((in_data || st == S_FIN) && is_wr);
  assign ad_o      = (st == S_ADDR) ? addr_q : wr_data;
  assign cbe_oe    = (st == S_ADDR) || in_data || (st == S_FIN);
  assign cbe_n_o   = (st == S_ADDR) ? cmd_q : ~ph_be;
  assign par_o     = par_q;
  assign par_oe    = par_oe_q;
  assign ph_idx    = idx_q;
  assign rd_data   = rd_data_q;
  assign rd_valid  = rd_valid_q;
  assign done      = (st == S_DONE);
  assign status    = status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cmd_q      <= '0;
      addr_q     <= '0;
      left_q     <= '0;
      idx_q      <= '0;
      tmr_q      <= '0;
      seen_q     <= 1'b0;
      status_q   <= END_OK;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      par_q      <= 1'b0;
      par_oe_q   <= 1'b0;
    end else begin
      par_q      <= ^{ad_o, cbe_n_o};
      par_oe_q   <= ad_oe;
      rd_valid_q <= xfer && !is_wr;
      if (xfer && !is_wr) rd_data_q <= ad_i;
      case (st)
        S_IDLE: if (req_valid) begin
          cmd_q  <= req_cmd;
          addr_q <= req_addr;
          left_q <= req_len;
          st     <= S_REQ;
        end
        S_REQ: if (!bus_gnt_n && frame_n_i && irdy_n_i) st <= S_ADDR;
        S_ADDR: begin
          idx_q  <= '0;
          tmr_q  <= '0;
          seen_q <= 1'b0;
          st     <= S_DATA;
        end
        S_DATA: begin
          if (!devsel_n_i) seen_q <= 1'b1;
          else if (!seen_q) tmr_q <= tmr_q + TW'(1);
          if (xfer) begin
            idx_q  <= idx_q + LEN_W'(1);
            left_q <= left_q - LEN_W'(1);
          end
          if (t_abort)      status_q <= END_TABT;
          else if (t_stop)  status_q <= END_STOP;
          else if (m_abort) status_q <= END_MABT;
          else              status_q <= END_OK;
          if (finish) st <= last ? S_TURN : S_FIN;
        end
        S_FIN:  st <= S_TURN;
        S_TURN: st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(frame_oe || irdy_oe || ad_oe || cbe_oe || par_oe || done));

  assert_frame_after_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_oe) |-> ($past(!bus_gnt_n) && $past(frame_n_i) && $past(irdy_n_i)));

  assert_irdy_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy_oe && !irdy_n_o) |-> frame_oe);

  assert_read_word_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!trdy_n_i && irdy_oe && !irdy_n_o && !ad_oe));

  assert_frame_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_n_o) && frame_oe) |-> !irdy_n_o);

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

endmodule

// File: tb/test_bus_initiator.sv
module test_bus_initiator;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 1'b0, req_ready;
  logic [3:0] req_cmd = '0;
  logic [31:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0, ph_idx;
  logic [31:0] wr_data, rd_data, ad_o;
  logic [31:0] ad_i = '0;
  logic [3:0] ph_be, cbe_n_o;
  logic rd_valid, done, bus_req_n;
  logic [1:0] status;
  logic bus_gnt_n = 1'b1;
  logic frame_n_o, frame_oe, irdy_n_o, irdy_oe, ad_oe, cbe_oe, par_o, par_oe;
  logic trdy_n = 1'b1, devsel_n = 1'b1, stop_n = 1'b1, oth_busy = 1'b0;
  logic [15:0] be_tab = '0;
  logic frame_n_i, irdy_n_i;

  int tests = 0, fails = 0;
  bit finished = 0;

  function automatic logic [31:0] wdat(input int p);
    return 32'hC0DE_0000 ^ (p * 32'h0101_0011);
  endfunction
  function automatic logic [31:0] rdat(input int p);
    return 32'h5A00_0000 + p * 7;
  endfunction
  function automatic logic [3:0] bef(input int p);
    return 4'(be_tab >> (4 * (p % 4)));
  endfunction

  assign frame_n_i = frame_oe ? frame_n_o : !oth_busy;
  assign irdy_n_i  = irdy_oe ? irdy_n_o : !oth_busy;
  assign wr_data   = wdat(int'(ph_idx));
  assign ph_be     = bef(int'(ph_idx));

  bus_initiator #(.LEN_W(LEN_W), .DSEL_LIMIT(6)) i_bus_initiator (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len), .ph_idx(ph_idx),
    .wr_data(wr_data), .ph_be(ph_be), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .status(status), .bus_req_n(bus_req_n), .bus_gnt_n(bus_gnt_n),
    .frame_n_o(frame_n_o), .frame_oe(frame_oe), .frame_n_i(frame_n_i),
    .irdy_n_o(irdy_n_o), .irdy_oe(irdy_oe), .irdy_n_i(irdy_n_i),
    .trdy_n_i(trdy_n), .devsel_n_i(devsel_n), .stop_n_i(stop_n),
    .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .cbe_n_o(cbe_n_o), .cbe_oe(cbe_oe),
    .par_o(par_o), .par_oe(par_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic run(input logic [3:0] cmd, input logic [31:0] addr, input int len,
                     input logic [15:0] bet, input int gd, input int bz, input int dd,
                     input int w, input int sp, input int sk, input logic [1:0] est);
    int nlen, p, dcyc, wc;
    bit wr, seen, last, endx, fin, rvp, stp, dv, tr, ta, ts, xf, nm, ma, prev_oe;
    logic [31:0] rvexp, prev_ad;
    logic [3:0] prev_cbe;
    string stag;
    nlen = (len < 1) ? 1 : len;
    wr = cmd[0];
    stag = (est == 2'd0) ? "R13" : (est == 2'd1) ? "R9" : (est == 2'd2) ? "R8" : "R10";

    @(negedge clk);
    chk_eq("R1 idle ready", {31'b0, req_ready}, 32'd1);
    chk_eq("R1 idle no drive", {28'b0, frame_oe, ad_oe, cbe_oe, done}, 32'd0);
    be_tab = bet; req_cmd = cmd; req_addr = addr; req_len = LEN_W'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < gd + bz; i++) begin
      chk_eq("R2 request held", {31'b0, bus_req_n}, 32'd0);
      chk_eq("R2 no frame before grant/idle", {31'b0, frame_oe}, 32'd0);
      bus_gnt_n = (i < gd);
      oth_busy  = (i >= gd);
      @(negedge clk);
    end
    chk_eq("R2 request held", {31'b0, bus_req_n}, 32'd0);
    chk_eq("R2 no frame yet", {31'b0, frame_oe}, 32'd0);
    bus_gnt_n = 1'b0; oth_busy = 1'b0;
    @(negedge clk);

    chk_eq("R3 addr frame", {29'b0, frame_oe, frame_n_o, bus_req_n}, 32'b100);
    chk_eq("R3 addr irdy high", {30'b0, irdy_oe, irdy_n_o}, 32'b11);
    chk_eq("R3 addr AD", ad_o, addr);
    chk_eq("R3 addr cmd", {27'b0, ad_oe, cbe_n_o}, {27'b0, 1'b1, cmd});
    chk_eq("R7 no parity before addr", {31'b0, par_oe}, 32'd0);
    prev_oe = 1'b1; prev_ad = addr; prev_cbe = cmd;
    bus_gnt_n = 1'b1;
    @(negedge clk);

    p = 0; dcyc = 0; wc = 0; seen = 0; endx = 0; fin = 0; rvp = 0; rvexp = '0;
    while (!endx) begin
      last = (p == nlen - 1);
      chk_eq("R4 irdy low in data", {30'b0, irdy_oe, irdy_n_o}, 32'b10);
      chk_eq("R4 frame level", {31'b0, frame_n_o}, {31'b0, last});
      chk_eq("R4 phase index", {24'b0, ph_idx}, p);
      chk_eq("R6 byte enables", {28'b0, cbe_n_o}, {28'b0, ~bef(p)});
      chk_eq("R5 AD enable", {31'b0, ad_oe}, {31'b0, wr});
      if (wr) chk_eq("R5 write data", ad_o, wdat(p));
      chk_eq("R7 parity enable", {31'b0, par_oe}, {31'b0, prev_oe});
      if (prev_oe) chk_eq("R7 even parity", {31'b0, par_o}, {31'b0, ^{prev_ad, prev_cbe}});
      chk_eq("R5 read strobe", {31'b0, rd_valid}, {31'b0, rvp});
      if (rvp) chk_eq("R5 read word", rd_data, rvexp);
      prev_oe = wr; prev_ad = wdat(p); prev_cbe = ~bef(p);

      dcyc++;
      stp = (p == sp) && (wc >= w) && (sk == 2 || dcyc > dd);
      dv  = (dcyc > dd) && !(stp && sk == 2);
      tr  = stp ? (sk == 0) : ((dcyc > dd) && (wc >= w));
      devsel_n = !dv; trdy_n = !tr; stop_n = !stp;
      ad_i = wr ? 32'hFFFF_FFFF : rdat(p);
      ta = stp && !dv; ts = stp && dv;
      xf = tr && !ta;
      nm = xf && last && !stp;
      ma = !seen && !dv && !stp && (dcyc == 6);
      rvp = xf && !wr; rvexp = rdat(p);
      if (dv) seen = 1;
      if (xf) begin p++; wc = 0; end else wc++;
      if (ta || ts || nm || ma) begin endx = 1; fin = !last; end
      @(negedge clk);
    end
    devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;

    if (fin) begin
      chk_eq("R11 frame released", {30'b0, frame_oe, frame_n_o}, 32'b11);
      chk_eq("R11 irdy still low", {30'b0, irdy_oe, irdy_n_o}, 32'b10);
      chk_eq("R5 read strobe", {31'b0, rd_valid}, {31'b0, rvp});
      if (rvp) chk_eq("R5 read word", rd_data, rvexp);
      chk_eq("R7 parity enable", {31'b0, par_oe}, {31'b0, prev_oe});
      if (prev_oe) chk_eq("R7 even parity", {31'b0, par_o}, {31'b0, ^{prev_ad, prev_cbe}});
      rvp = 0; prev_oe = wr; prev_ad = wdat(p); prev_cbe = ~bef(p);
      @(negedge clk);
    end

    chk_eq("R12 turnaround ctl", {28'b0, frame_oe, frame_n_o, irdy_oe, irdy_n_o}, 32'b1111);
    chk_eq("R12 turnaround release", {29'b0, ad_oe, cbe_oe, done}, 32'd0);
    chk_eq("R5 read strobe", {31'b0, rd_valid}, {31'b0, rvp});
    if (rvp) chk_eq("R5 read word", rd_data, rvexp);
    chk_eq("R7 parity enable", {31'b0, par_oe}, {31'b0, prev_oe});
    if (prev_oe) chk_eq("R7 even parity", {31'b0, par_o}, {31'b0, ^{prev_ad, prev_cbe}});
    @(negedge clk);

    chk_eq("R12 done pulse", {31'b0, done}, 32'd1);
    chk_eq({stag, " status"}, {30'b0, status}, {30'b0, est});
    chk_eq("R12 all released", {27'b0, frame_oe, irdy_oe, ad_oe, cbe_oe, par_oe}, 32'd0);
    chk_eq("R12 not ready during done", {31'b0, req_ready}, 32'd0);
  endtask

  initial begin
    #1;
    chk_eq("R1 reset enables", {27'b0, frame_oe, irdy_oe, ad_oe, cbe_oe, par_oe}, 32'd0);
    chk_eq("R1 reset req/done/ready", {29'b0, bus_req_n, done, req_ready}, 32'b101);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // write burst with grant delay, foreign traffic, devsel and waits
    run(4'b0111, 32'h1000_0040, 3, 16'h0F3C, 2, 2, 1, 1, -1, 0, 2'd0);
    // read burst, fast target, first phase with no byte enables
    run(4'b0110, 32'h2000_0000, 2, 16'h00F0, 0, 0, 0, 0, -1, 0, 2'd0);
    // length 0 runs one phase (R4)
    run(4'b1010, 32'h0000_0104, 0, 16'h000F, 1, 3, 2, 0, -1, 0, 2'd0);
    // no target: master abort mid burst (R8, R11)
    run(4'b0010, 32'h0000_03F8, 2, 16'h00FF, 0, 0, 99, 0, -1, 0, 2'd2);
    // no target: master abort on single phase (R8)
    run(4'b0011, 32'h0000_03FC, 1, 16'h0001, 0, 1, 99, 0, -1, 0, 2'd2);
    // devsel on 6th clock just avoids abort (R8 boundary)
    run(4'b0110, 32'h3000_0010, 1, 16'h000F, 0, 0, 5, 0, -1, 0, 2'd0);
    // disconnect with data at phase 1 of 4 (R9, R11)
    run(4'b0111, 32'h4000_0000, 4, 16'h5A0F, 1, 0, 0, 0, 1, 0, 2'd1);
    // target abort at phase 1 (R10, R11)
    run(4'b0110, 32'h5000_0020, 3, 16'hFFFF, 0, 0, 0, 1, 1, 2, 2'd3);
    // retry without data, single phase (R9)
    run(4'b1011, 32'h0000_0008, 1, 16'h0003, 0, 0, 3, 0, 0, 1, 2'd1);
    @(negedge clk);
    chk_eq("R1 idle after last", {31'b0, req_ready}, 32'd1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule